// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the transaction engine of an SMBus host controller. A processor reaches it through a simple byte-wide register port. Software loads the target address, a command byte and data. It then writes the control register with a protocol code and the start bit. The sequencer walks the chosen SMBus protocol as a series of byte-level operations on a bus-master engine: start or repeated start, send a byte, receive a byte with ACK or NACK, and stop. Bit timing on SCL and SDA is left to that engine.

Block transfers move one byte at a time through a single data register. Each byte sets a byte-done flag and the sequencer pauses until software clears it, so software can refill or drain the register. Errors reported by the bus engine are latched in the status register and the transfer always closes with a stop. Software can abort a running transfer with a kill bit.

Register map (byte offsets): 0 status, 1 control, 2 command, 3 address (bits 7:1 device address, bit 0 = 1 for read), 4 data0, 5 data1, 6 block data. Status bits: 7 byte-done, 4 failed, 3 bus error, 2 device error, 1 done, 0 busy (read-only). Control bits: 6 start (reads 0), 5 last-byte, 4:2 protocol, 1 kill. Protocol codes: 0 quick, 1 byte, 2 byte-data, 3 word, 5 block, 6 I2C block; 4 and 7 are unsupported. Bus operation codes on `bm_op`: 0 start (also repeated start), 1 send byte, 2 receive byte, 3 stop. Response codes on `bm_resp`: 0 ok, 1 NACK, 2 arbitration lost, 3 bus fault.

Top module: `smb_host_seq`

## Requirements
- R1: After reset the status and control registers read 0 and no bus operation is requested.
- R2: While idle, the command, address, data0, data1 and block data registers read back the last value written to them.
- R3: Quick issues start, address byte, stop. Byte write issues start, address, command, stop. Byte read issues start, address, a received byte with NACK that lands in data0, then stop.
- R4: Byte-data and word writes send address, command, data0 (and data1 for word). Their reads send the address with bit 0 cleared, the command, a repeated start and the address with bit 0 set. The first received byte goes to data0 and is ACKed only for word. For word the second byte goes to data1 with NACK.
- R5: Block write sends data0 as the count byte. It then sends count bytes taken from block data. After each byte it sets byte-done and waits until software writes one to status bit 7 before the next byte or the stop.
- R6: Block read stores the received count byte in data0. A count outside 1..32 ends the transfer with a stop and the failed bit. Otherwise it receives count bytes into block data with a byte-done pause after each one, and NACKs the last byte.
- R7: I2C block transfers send no count byte. A write sends data0 bytes from block data. A read takes its command byte from data1, and it NACKs and ends after the byte that was received while the control last-byte bit was set.
- R8: A NACK response on any sent or received byte sets device error (bit 2). Arbitration loss or bus fault sets bus error (bit 3). In both cases the next operation is a stop.
- R9: Busy (bit 0) is set from the accepted start write until the stop operation completes. Done (bit 1) is set at that point only when no error or abort occurred.
- R10: Writing a one to status bits 7, 4, 3, 2 or 1 clears that bit, and writing a zero leaves it unchanged.
- R11: Writing kill while busy aborts at the next byte boundary, issues a stop and sets failed (bit 4). The kill bit reads 1 until the stop completes. A kill written while idle has no effect and reads 0.
- R12: A control write with start while busy is ignored entirely. Starting protocol 4 or 7, or a block or I2C block write whose data0 is outside 1..32, sets failed without any bus operation.
- R13: A bus operation request stays asserted with the same operation code until the engine returns its completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| bm_req | output | 1 | Bus operation request |
| bm_op | output | 2 | Bus operation code |
| bm_wbyte | output | 8 | Byte to send |
| bm_nack | output | 1 | NACK the byte being received |
| bm_done | input | 1 | Bus operation complete pulse |
| bm_resp | input | 2 | Completion response code |
| bm_rbyte | input | 8 | Received byte |

## Verification
The hardest situations to reach are those that depend on what software does while a block transfer is paused on byte-done: a kill, a stray start, or a late change of the last-byte bit. From the ports these only occur inside that pause. The bench reaches them by polling status in its service loop and acting on a chosen byte index before it clears byte-done. A behavioural bus-engine model holds the expected operation list for each transfer and compares every accepted operation, so any extra, missing or wrongly ACKed byte shows up at the exact step where it happens.

// File: rtl/smb_host_seq.sv
module smb_host_seq #(
  parameter int BLK_MAX = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bm_req,
  output logic [1:0] bm_op,
  output logic [7:0] bm_wbyte,
  output logic       bm_nack,
  input  logic       bm_done,
  input  logic [1:0] bm_resp,
  input  logic [7:0] bm_rbyte
);

  localparam logic [7:0] MAXB = 8'(BLK_MAX);
  localparam logic [2:0] P_QUICK = 3'd0, P_BYTE = 3'd1, P_BDATA = 3'd2,
                         P_WORD = 3'd3, P_BLK = 3'd5, P_I2C = 3'd6;
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {
    K_IDLE, K_START, K_ADDR, K_CMD, K_RS, K_ADDRR, K_WD0, K_WD1,
    K_RD0, K_RD1, K_WCNT, K_RCNT, K_BW, K_BR, K_WAIT, K_STOP
  } kind_t;

  kind_t      kind_q, nxt;
  logic [7:0] cmd_q, adr_q, d0_q, d1_q, blk_q, rem_q;
  logic [2:0] proto_q;
  logic       last_q, kill_q, fin_q;
  logic       p_dev, p_bus, p_fail;
  logic       st_bd, st_fail, st_berr, st_derr, st_done;
  logic       busy, rw, rd_comb, start_bad;

  function automatic logic cnt_ok(input logic [7:0] c);
    return (c != 8'd0) && (c <= MAXB);
  endfunction

  assign busy    = (kind_q != K_IDLE);
  assign rw      = adr_q[0];
  assign rd_comb = rw && (proto_q inside {P_BDATA, P_WORD, P_BLK, P_I2C});

  assign start_bad = (reg_wdata[4:2] == 3'd4) || (reg_wdata[4:2] == 3'd7) ||
                     ((reg_wdata[4:2] == P_BLK || reg_wdata[4:2] == P_I2C) && !rw && !cnt_ok(d0_q));

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {st_bd, 2'b00, st_fail, st_berr, st_derr, st_done, busy};
      3'd1:    reg_rdata = {2'b00, last_q, proto_q, kill_q, 1'b0};
      3'd2:    reg_rdata = cmd_q;
      3'd3:    reg_rdata = adr_q;
      3'd4:    reg_rdata = d0_q;
      3'd5:    reg_rdata = d1_q;
      3'd6:    reg_rdata = blk_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign bm_req = busy && (kind_q != K_WAIT);

  always_comb begin
    bm_op    = OP_SEND;
    bm_wbyte = 8'h00;
    bm_nack  = 1'b0;
    case (kind_q)
      K_START, K_RS: bm_op = OP_START;
      K_STOP:        bm_op = OP_STOP;
      K_ADDR:        bm_wbyte = rd_comb ? {adr_q[7:1], 1'b0} : adr_q;
      K_ADDRR:       bm_wbyte = {adr_q[7:1], 1'b1};
      K_CMD:         bm_wbyte = (proto_q == P_I2C && rw) ? d1_q : cmd_q;
      K_WD0, K_WCNT: bm_wbyte = d0_q;
      K_WD1:         bm_wbyte = d1_q;
      K_BW:          bm_wbyte = blk_q;
      K_RD0: begin bm_op = OP_RECV; bm_nack = (proto_q != P_WORD); end
      K_RD1: begin bm_op = OP_RECV; bm_nack = 1'b1; end
      K_RCNT:        bm_op = OP_RECV;
      K_BR: begin bm_op = OP_RECV; bm_nack = (proto_q == P_I2C) ? last_q : (rem_q == 8'd1); end
      default: ;
    endcase
  end

  always_comb begin
    nxt = K_STOP;
    case (kind_q)
      K_START: nxt = K_ADDR;
      K_ADDR:  nxt = (proto_q == P_QUICK) ? K_STOP : (proto_q == P_BYTE && rw) ? K_RD0 : K_CMD;
      K_CMD: begin
        if (proto_q == P_BYTE)                         nxt = K_STOP;
        else if (rw)                                   nxt = K_RS;
        else if (proto_q == P_BDATA || proto_q == P_WORD) nxt = K_WD0;
        else if (proto_q == P_BLK)                     nxt = K_WCNT;
        else                                           nxt = K_BW;
      end
      K_RS:    nxt = K_ADDRR;
      K_ADDRR: nxt = (proto_q == P_BLK) ? K_RCNT : (proto_q == P_I2C) ? K_BR : K_RD0;
      K_WD0:   nxt = (proto_q == P_WORD) ? K_WD1 : K_STOP;
      K_RD0:   nxt = (proto_q == P_WORD) ? K_RD1 : K_STOP;
      K_WCNT:  nxt = K_BW;
      K_RCNT:  nxt = K_BR;
      K_BW, K_BR: nxt = K_WAIT;
      default: nxt = K_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_IDLE;
      cmd_q   <= '0; adr_q <= '0; d0_q <= '0; d1_q <= '0; blk_q <= '0; rem_q <= '0;
      proto_q <= '0; last_q <= 1'b0; kill_q <= 1'b0; fin_q <= 1'b0;
      p_dev   <= 1'b0; p_bus <= 1'b0; p_fail <= 1'b0;
      st_bd   <= 1'b0; st_fail <= 1'b0; st_berr <= 1'b0; st_derr <= 1'b0; st_done <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            if (reg_wdata[7]) st_bd   <= 1'b0;
            if (reg_wdata[4]) st_fail <= 1'b0;
            if (reg_wdata[3]) st_berr <= 1'b0;
            if (reg_wdata[2]) st_derr <= 1'b0;
            if (reg_wdata[1]) st_done <= 1'b0;
          end
          3'd1: begin
            if (!busy) begin
              last_q  <= reg_wdata[5];
              proto_q <= reg_wdata[4:2];
              if (reg_wdata[6]) begin
                if (start_bad) st_fail <= 1'b1;
                else begin
                  kind_q <= K_START;
                  p_dev  <= 1'b0; p_bus <= 1'b0; p_fail <= 1'b0;
                  fin_q  <= 1'b0;
                  rem_q  <= d0_q;
                end
              end
            end else if (!reg_wdata[6]) begin
              last_q <= reg_wdata[5];
              if (reg_wdata[1]) kill_q <= 1'b1;
            end
          end
          3'd2: if (!busy) cmd_q <= reg_wdata;
          3'd3: if (!busy) adr_q <= reg_wdata;
          3'd4: if (!busy) d0_q  <= reg_wdata;
          3'd5: if (!busy) d1_q  <= reg_wdata;
          3'd6: blk_q <= reg_wdata;
          default: ;
        endcase
      end

      case (kind_q)
        K_IDLE: ;
        K_WAIT: begin
          if (kill_q) begin
            p_fail <= 1'b1;
            kind_q <= K_STOP;
          end else if (!st_bd) begin
            kind_q <= fin_q ? K_STOP : (rw ? K_BR : K_BW);
          end
        end
        K_STOP: begin
          if (bm_done) begin
            kind_q <= K_IDLE;
            kill_q <= 1'b0;
            if (p_dev)  st_derr <= 1'b1;
            if (p_bus)  st_berr <= 1'b1;
            if (p_fail) st_fail <= 1'b1;
            if (!(p_dev || p_bus || p_fail)) st_done <= 1'b1;
          end
        end
        default: begin
          if (bm_done) begin
            if (bm_resp != 2'd0) begin
              if (bm_resp == 2'd1) p_dev <= 1'b1;
              else                 p_bus <= 1'b1;
              kind_q <= K_STOP;
            end else begin
              case (kind_q)
                K_RD0:  d0_q  <= bm_rbyte;
                K_RD1:  d1_q  <= bm_rbyte;
                K_RCNT: begin d0_q <= bm_rbyte; rem_q <= bm_rbyte; end
                K_BR:   blk_q <= bm_rbyte;
                default: ;
              endcase
              if (kind_q == K_BW || kind_q == K_BR) begin
                st_bd <= 1'b1;
                fin_q <= (kind_q == K_BR && proto_q == P_I2C) ? last_q : (rem_q == 8'd1);
                rem_q <= rem_q - 8'd1;
              end
              if (kill_q) begin
                p_fail <= 1'b1;
                kind_q <= K_STOP;
              end else if (kind_q == K_RCNT && !cnt_ok(bm_rbyte)) begin
                p_fail <= 1'b1;
                kind_q <= K_STOP;
              end else begin
                kind_q <= nxt;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/smb_host_seq_sva.sv
module smb_host_seq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       bm_req,
  input logic [1:0] bm_op,
  input logic       bm_done,
  input logic       busy,
  input logic       kill_q,
  input logic       st_done,
  input logic       st_bd
);

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && !bm_done) |=> (bm_req && $stable(bm_op)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bm_req);

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_op == 2'd3 && bm_done) |=> !busy);

  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $fell(busy));

  a_r11_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !kill_q);

  a_r5_bd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_bd) |-> busy);

endmodule

bind smb_host_seq smb_host_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bm_req(bm_req), .bm_op(bm_op), .bm_done(bm_done),
  .busy(busy), .kill_q(kill_q), .st_done(st_done), .st_bd(st_bd)
);

// File: tb/smb_host_seq_bench.sv
module smb_host_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic bm_req, bm_nack;
  logic [1:0] bm_op;
  logic [7:0] bm_wbyte;
  logic bm_done = 1'b0;
  logic [1:0] bm_resp = '0;
  logic [7:0] bm_rbyte = '0;

  always #2 clk = ~clk;

  smb_host_seq u_smb_host_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bm_req(bm_req), .bm_op(bm_op), .bm_wbyte(bm_wbyte), .bm_nack(bm_nack),
    .bm_done(bm_done), .bm_resp(bm_resp), .bm_rbyte(bm_rbyte)
  );

  typedef struct packed {
    logic [1:0] op; logic [7:0] b; logic nack; logic [1:0] resp; logic [7:0] rb;
  } ev_t;

  ev_t q[$];
  int n_tests = 0, n_fail = 0, sl_cnt = 0, nbd = 0;
  bit ended = 0;
  logic [1:0] cur_resp;
  logic [7:0] cur_rb;
  logic [7:0] wb[8];
  logic [7:0] rb[8];

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural bus-engine model: pops expected op, compares, answers after 2 cycles
  always @(posedge clk) begin
    if (bm_done) bm_done <= 1'b0;
    else if (sl_cnt == 0 && bm_req) begin
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R13 unexpected bus op: actual %0d expected none", bm_op);
        cur_resp = 2'd0; cur_rb = 8'h00;
      end else begin
        ev_t e;
        e = q.pop_front();
        chk("R13 bus op code", bm_op, e.op);
        if (e.op == 2'd1) chk("R3/R4/R5 sent byte", bm_wbyte, e.b);
        if (e.op == 2'd2) chk("R4/R6/R7 ack-nack choice", bm_nack, e.nack);
        cur_resp = e.resp; cur_rb = e.rb;
      end
      sl_cnt <= 2;
    end else if (sl_cnt == 1) begin
      bm_done <= 1'b1; bm_resp <= cur_resp; bm_rbyte <= cur_rb; sl_cnt <= 0;
    end else if (sl_cnt > 1) sl_cnt <= sl_cnt - 1;
  end

  task automatic e_start(); q.push_back('{2'd0, 8'h00, 1'b0, 2'd0, 8'h00}); endtask
  task automatic e_stop();  q.push_back('{2'd3, 8'h00, 1'b0, 2'd0, 8'h00}); endtask
  task automatic e_w(input logic [7:0] b, input logic [1:0] r); q.push_back('{2'd1, b, 1'b0, r, 8'h00}); endtask
  task automatic e_r(input logic n, input logic [7:0] d); q.push_back('{2'd2, 8'h00, n, 2'd0, d}); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run(input int mode, input int n);
    logic [7:0] s, c;
    int k = 0;
    for (int t = 0; t < 3000; t++) begin
      rd(3'd0, s);
      if (!s[0]) break;
      if (s[7] && mode != 0 && !(mode == 4 && k > 0)) begin
        case (mode)
          1: begin
            if (k == 0) begin
              wr(3'd1, 8'h40);
              rd(3'd1, c);
              chk("R12 start while busy ignored", int'(c[4:2]), 5);
            end
            if (k + 1 < n) wr(3'd6, wb[k+1]);
          end
          2, 3: begin
            rd(3'd6, c); rb[k] = c;
            if (mode == 3 && k == n - 2) wr(3'd1, 8'h38);
          end
          4: begin
            wr(3'd1, 8'h02);
            rd(3'd1, c);
            chk("R11 kill reads 1 during abort", int'(c[1]), 1);
          end
          default: ;
        endcase
        k++;
        if (mode != 4) wr(3'd0, 8'h80);
      end
      @(negedge clk);
    end
    nbd = k;
    chk("R9 all expected ops consumed", q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!ended) begin ended = 1; $display("[TB] %0d tests run, %0d failed", n_tests, n_fail); end
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, s); chk("R1 status after reset", s, 8'h00);
    rd(3'd1, s); chk("R1 control after reset", s, 8'h00);
    chk("R1 no request after reset", bm_req, 0);

    wr(3'd2, 8'h3C); rd(3'd2, s); chk("R2 command readback", s, 8'h3C);
    wr(3'd5, 8'hC5); rd(3'd5, s); chk("R2 data1 readback", s, 8'hC5);

    // R3 quick
    wr(3'd3, 8'hA0); e_start(); e_w(8'hA0, 2'd0); e_stop();
    wr(3'd1, 8'h40);
    rd(3'd0, s); chk("R9 busy right after start", int'(s[0]), 1);
    run(0, 0);
    rd(3'd0, s); chk("R3 R9 quick done", s, 8'h02);

    // R3 byte read
    wr(3'd0, 8'hFF); wr(3'd3, 8'hA1);
    e_start(); e_w(8'hA1, 2'd0); e_r(1'b1, 8'h5A); e_stop();
    wr(3'd1, 8'h44); run(0, 0);
    rd(3'd4, s); chk("R3 byte read data0", s, 8'h5A);
    rd(3'd0, s); chk("R3 byte read status", s, 8'h02);

    // R4 byte-data write
    wr(3'd0, 8'hFF); wr(3'd3, 8'hA0); wr(3'd2, 8'h10); wr(3'd4, 8'h77);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h10, 2'd0); e_w(8'h77, 2'd0); e_stop();
    wr(3'd1, 8'h48); run(0, 0);
    rd(3'd0, s); chk("R4 byte-data write status", s, 8'h02);

    // R4 word read
    wr(3'd0, 8'hFF); wr(3'd3, 8'hA1); wr(3'd2, 8'h22);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h22, 2'd0); e_start(); e_w(8'hA1, 2'd0);
    e_r(1'b0, 8'h34); e_r(1'b1, 8'h12); e_stop();
    wr(3'd1, 8'h4C); run(0, 0);
    rd(3'd4, s); chk("R4 word low in data0", s, 8'h34);
    rd(3'd5, s); chk("R4 word high in data1", s, 8'h12);

    // R8 NACK on address
    wr(3'd0, 8'hFF); wr(3'd3, 8'hA0);
    e_start(); e_w(8'hA0, 2'd1); e_stop();
    wr(3'd1, 8'h48); run(0, 0);
    rd(3'd0, s); chk("R8 device error, no done", s, 8'h04);

    // R8 arbitration lost on data
    wr(3'd0, 8'hFF); wr(3'd2, 8'h01); wr(3'd4, 8'h02);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h01, 2'd0); e_w(8'h02, 2'd2); e_stop();
    wr(3'd1, 8'h4C); run(0, 0);
    rd(3'd0, s); chk("R8 bus error, no done", s, 8'h08);

    // R5 block write with R12 stray start
    wr(3'd0, 8'hFF); wr(3'd2, 8'h30); wr(3'd4, 8'h03);
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wr(3'd6, wb[0]);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h30, 2'd0); e_w(8'h03, 2'd0);
    e_w(8'h11, 2'd0); e_w(8'h22, 2'd0); e_w(8'h33, 2'd0); e_stop();
    wr(3'd1, 8'h54); run(1, 3);
    chk("R5 byte-done per byte", nbd, 3);
    rd(3'd0, s); chk("R5 block write status", s, 8'h02);

    // R6 block read count 2
    wr(3'd0, 8'hFF); wr(3'd3, 8'hA1); wr(3'd2, 8'h31);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h31, 2'd0); e_start(); e_w(8'hA1, 2'd0);
    e_r(1'b0, 8'h02); e_r(1'b0, 8'hAA); e_r(1'b1, 8'hBB); e_stop();
    wr(3'd1, 8'h54); run(2, 2);
    chk("R6 first block byte", rb[0], 8'hAA);
    chk("R6 second block byte", rb[1], 8'hBB);
    rd(3'd4, s); chk("R6 count in data0", s, 8'h02);
    rd(3'd0, s); chk("R6 block read status", s, 8'h02);

    // R6 bad count
    wr(3'd0, 8'hFF);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h31, 2'd0); e_start(); e_w(8'hA1, 2'd0);
    e_r(1'b0, 8'h21); e_stop();
    wr(3'd1, 8'h54); run(0, 0);
    rd(3'd0, s); chk("R6 count over limit fails", s, 8'h10);

    // R7 I2C block read, command from data1
    wr(3'd0, 8'hFF); wr(3'd5, 8'h44); wr(3'd2, 8'h99);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h44, 2'd0); e_start(); e_w(8'hA1, 2'd0);
    e_r(1'b0, 8'hC1); e_r(1'b0, 8'hC2); e_r(1'b1, 8'hC3); e_stop();
    wr(3'd1, 8'h58); run(3, 3);
    chk("R7 I2C read byte count", nbd, 3);
    chk("R7 I2C read last byte", rb[2], 8'hC3);
    rd(3'd0, s); chk("R7 I2C read status", s, 8'h02);

    // R7 I2C block write, no count byte
    wr(3'd0, 8'hFF); wr(3'd3, 8'hA0); wr(3'd2, 8'h55); wr(3'd4, 8'h02);
    wb[0] = 8'hD1; wb[1] = 8'hD2; wr(3'd6, wb[0]);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h55, 2'd0); e_w(8'hD1, 2'd0); e_w(8'hD2, 2'd0); e_stop();
    wr(3'd1, 8'h18);
    wr(3'd1, 8'h58);
    begin
      int k = 0;
      for (int t = 0; t < 3000; t++) begin
        rd(3'd0, s);
        if (!s[0]) break;
        if (s[7]) begin if (k == 0) wr(3'd6, wb[1]); k++; wr(3'd0, 8'h80); end
        @(negedge clk);
      end
    end
    chk("R7 I2C write ops consumed", q.size(), 0);
    rd(3'd0, s); chk("R7 I2C write status", s, 8'h02);

    // R11 kill during byte-done pause
    wr(3'd0, 8'hFF); wr(3'd2, 8'h30); wr(3'd4, 8'h02); wr(3'd6, 8'hE1);
    e_start(); e_w(8'hA0, 2'd0); e_w(8'h30, 2'd0); e_w(8'h02, 2'd0); e_w(8'hE1, 2'd0); e_stop();
    wr(3'd1, 8'h54); run(4, 2);
    rd(3'd0, s); chk("R11 kill sets failed", s, 8'h90);
    rd(3'd1, s); chk("R11 kill self-clears", int'(s[1]), 0);

    // R11 kill while idle
    wr(3'd0, 8'hFF); wr(3'd1, 8'h02);
    rd(3'd1, s); chk("R11 idle kill ignored", int'(s[1]), 0);
    rd(3'd0, s); chk("R11 idle kill no status", s, 8'h00);

    // R12 unsupported protocol and zero block count
    wr(3'd1, 8'h50); repeat (6) @(negedge clk);
    rd(3'd0, s); chk("R12 protocol 4 fails without bus", s, 8'h10);
    wr(3'd0, 8'hFF); wr(3'd4, 8'h00); wr(3'd1, 8'h54); repeat (6) @(negedge clk);
    rd(3'd0, s); chk("R12 zero count fails without bus", s, 8'h10);

    // R10 write-one-to-clear
    wr(3'd0, 8'h08); rd(3'd0, s); chk("R10 zero bit keeps failed", s, 8'h10);
    wr(3'd0, 8'h10); rd(3'd0, s); chk("R10 one bit clears failed", s, 8'h00);

    if (!ended) begin ended = 1; $display("[TB] %0d tests run, %0d failed", n_tests, n_fail); end
    $finish;
  end
endmodule